// File: doc/BRIEF.md
# Six-Hour Alarm Clock Controller

This block keeps time in a day of six hours, each ten minutes long, and raises a visual alarm when the running time reaches a preset value. A free-running divider turns the system clock into a one-pulse-per-period enable. On each pulse the time advances by one minute. The time is held as two BCD digits, an hour digit from 0 to 5 and a minute digit from 0 to 9. Both digits are driven to a pair of seven-segment patterns, with the hour on the left and the minute on the right.

A four-state controller works alongside the counter. It starts in a load state, where it captures the alarm hour and minute inputs. It then keeps time until the running time equals the captured alarm time. When that happens it shows an alarm pattern made only of the decimal-point segments, and it holds that pattern until the snooze input is raised. The snooze input is synchronized by two flops before use. After a snooze, the alarm stays disarmed until the time has moved away from the alarm time. The divider ratio is a parameter, so that a short ratio can be used for fast checking.

Top module: `mixed_alarm_clock`

## Requirements
- R1: While `rst_n` is low, and without waiting for a clock edge, the time is 0:0, `state` reads INIT (code 0) and both segment outputs show the digit 0 (8'h3F).
- R2: The minute advances by exactly one once every TICK_DIV clock cycles. At every other edge the time is unchanged.
- R3: Minute 9 rolls to 0 and carries into the hour. Time 5:9 rolls to 0:0.
- R4: Segment bits are {dp,g,f,e,d,c,b,a}, active high. The digits 0 to 9 encode as 3F,06,5B,4F,66,6D,7D,07,7F,6F. `seg_hour` shows the hour and `seg_min` shows the minute whenever `state` is INIT or TIME.
- R5: INIT lasts one cycle after reset is released internally. In that cycle it captures `alarm_hour` and `alarm_min`, then moves to TIME (code 1).
- R6: In TIME, the clock edge that follows the running time becoming equal to the captured alarm time moves the state to ALARM (code 2).
- R7: ALARM lasts exactly one cycle and is followed by SNOOZE (code 3).
- R8: In ALARM and in SNOOZE, both segment outputs are 8'h80, meaning only the decimal point is lit. SNOOZE holds while the snooze input is low. The time keeps counting throughout.
- R9: A high snooze input leaves SNOOZE for TIME at the third rising edge after it is applied, because of the two-flop synchronizer.
- R10: After a snooze, the alarm does not fire again while the time still equals the alarm time. It fires again only once the time has differed from the alarm time and then matched it again.
- R11: Changes to `alarm_hour` or `alarm_min` after INIT are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snooze_btn | input | 1 | Snooze request, asynchronous to clk |
| alarm_hour | input | 4 | Alarm hour in BCD, 0 to 5 |
| alarm_min | input | 4 | Alarm minute in BCD, 0 to 9 |
| seg_hour | output | 8 | Left digit segments {dp,g,f,e,d,c,b,a} |
| seg_min | output | 8 | Right digit segments {dp,g,f,e,d,c,b,a} |
| hour_bcd | output | 4 | Current hour digit |
| min_bcd | output | 4 | Current minute digit |
| state | output | 2 | Controller state: 0 INIT, 1 TIME, 2 ALARM, 3 SNOOZE |

## Verification
The embedded assertions check, on every cycle, the properties that follow from local state. These are: the digit ranges, the time holding between enables, the 5:9 wrap, the single-cycle INIT and ALARM states, SNOOZE holding or releasing according to the synchronized snooze input, no alarm entry while disarmed, and the captured alarm time staying frozen after INIT. The bench sweeps two full days and a third partial day. Only those scenarios show that the period equals TICK_DIV, that the segment patterns are correct, that the snooze latency through the synchronizer is right, that changed alarm inputs are ignored, and that the alarm fires on an unchanged time, including the boundary value 5:9.

// File: rtl/alarm_clk_pkg.sv
package alarm_clk_pkg;

  localparam int DIG_W = 4;
  localparam int SEG_W = 8;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TIME   = 2'd1,
    ST_ALARM  = 2'd2,
    ST_SNOOZE = 2'd3
  } clk_state_e;

  localparam logic [SEG_W-1:0] SEG_ALARM = 8'h80;

  function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [DIG_W-1:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 8'h3F;
      4'd1: s = 8'h06;
      4'd2: s = 8'h5B;
      4'd3: s = 8'h4F;
      4'd4: s = 8'h66;
      4'd5: s = 8'h6D;
      4'd6: s = 8'h7D;
      4'd7: s = 8'h07;
      4'd8: s = 8'h7F;
      4'd9: s = 8'h6F;
      default: s = 8'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/clk_reset_sync.sv
module clk_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= 2'b00;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_n_o = rst_pipe_q[1];
endmodule

// File: rtl/clk_bit_sync.sv
module clk_bit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/clk_tick_div.sv
module clk_tick_div #(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  generate
    if (TICK_DIV > 1) begin : g_tick_chk
      AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R2
    end
  endgenerate
endmodule

// File: rtl/clk_time_count.sv
module clk_time_count
  import alarm_clk_pkg::*;
#(
  parameter int MIN_RADIX  = 10,
  parameter int HOUR_RADIX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [DIG_W-1:0] hour_o,
  output logic [DIG_W-1:0] min_o
);
  localparam logic [DIG_W-1:0] MIN_LAST  = DIG_W'(MIN_RADIX - 1);
  localparam logic [DIG_W-1:0] HOUR_LAST = DIG_W'(HOUR_RADIX - 1);

  logic [DIG_W-1:0] min_q, min_d;
  logic [DIG_W-1:0] hour_q, hour_d;

  always_comb begin
    min_d  = min_q;
    hour_d = hour_q;
    if (tick_i) begin
      if (min_q != MIN_LAST) begin
        min_d = min_q + 1'b1;
      end else begin
        min_d = '0;
        if (hour_q != HOUR_LAST) hour_d = hour_q + 1'b1;
        else                     hour_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q  <= '0;
      hour_q <= '0;
    end else if (tick_i) begin
      min_q  <= min_d;
      hour_q <= hour_d;
    end
  end

  assign hour_o = hour_q;
  assign min_o  = min_q;

  AST_MIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    min_q <= MIN_LAST); // R3
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hour_q <= HOUR_LAST); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(min_q) && $stable(hour_q))); // R2
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && min_q == MIN_LAST && hour_q == HOUR_LAST) |=> (min_q == '0 && hour_q == '0)); // R3
endmodule

// File: rtl/clk_alarm_fsm.sv
module clk_alarm_fsm
  import alarm_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snooze_i,
  input  logic [DIG_W-1:0] hour_i,
  input  logic [DIG_W-1:0] min_i,
  input  logic [DIG_W-1:0] set_hour_i,
  input  logic [DIG_W-1:0] set_min_i,
  output clk_state_e       state_o
);
  clk_state_e       state_q, state_d;
  logic [DIG_W-1:0] alm_h_q, alm_h_d;
  logic [DIG_W-1:0] alm_m_q, alm_m_d;
  logic             armed_q, armed_d;
  logic             match;

  assign match = (hour_i == alm_h_q) && (min_i == alm_m_q);

  always_comb begin
    state_d = state_q;
    alm_h_d = alm_h_q;
    alm_m_d = alm_m_q;
    armed_d = armed_q;
    case (state_q)
      ST_INIT: begin
        alm_h_d = set_hour_i;
        alm_m_d = set_min_i;
        armed_d = 1'b1;
        state_d = ST_TIME;
      end
      ST_TIME: begin
        if (match && armed_q) begin
          armed_d = 1'b0;
          state_d = ST_ALARM;
        end
      end
      ST_ALARM: state_d = ST_SNOOZE;
      ST_SNOOZE: begin
        if (snooze_i) state_d = ST_TIME;
      end
      default: state_d = ST_TIME;
    endcase
    if (!match && state_q != ST_INIT) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      alm_h_q <= '0;
      alm_m_q <= '0;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      alm_h_q <= alm_h_d;
      alm_m_q <= alm_m_d;
      armed_q <= armed_d;
    end
  end

  assign state_o = state_q;

  AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_INIT |=> state_q == ST_TIME); // R5
  AST_ALARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ALARM |=> state_q == ST_SNOOZE); // R7
  AST_SNOOZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SNOOZE && !snooze_i) |=> state_q == ST_SNOOZE); // R8
  AST_SNOOZE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SNOOZE && snooze_i) |=> state_q == ST_TIME); // R9
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TIME && !armed_q) |=> state_q != ST_ALARM); // R10
  AST_ALARM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_INIT |=> ($stable(alm_h_q) && $stable(alm_m_q))); // R11
endmodule

// File: rtl/mixed_alarm_clock.sv
module mixed_alarm_clock
  import alarm_clk_pkg::*;
#(
  parameter int TICK_DIV   = 50_000_000,
  parameter int MIN_RADIX  = 10,
  parameter int HOUR_RADIX = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       snooze_btn,
  input  logic [3:0] alarm_hour,
  input  logic [3:0] alarm_min,
  output logic [7:0] seg_hour,
  output logic [7:0] seg_min,
  output logic [3:0] hour_bcd,
  output logic [3:0] min_bcd,
  output logic [1:0] state
);
  localparam int N_DIG = 2;

  logic             rst_n_int;
  logic             snooze_s;
  logic             tick;
  logic [DIG_W-1:0] hour_w, min_w;
  clk_state_e       state_w;
  logic             show_alarm;
  logic [DIG_W-1:0] digit [N_DIG];
  logic [SEG_W-1:0] seg   [N_DIG];

  clk_reset_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  clk_bit_sync u_snooze_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (snooze_btn),
    .q_o   (snooze_s)
  );

  clk_tick_div #(.TICK_DIV(TICK_DIV)) u_tick_div (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick_o (tick)
  );

  clk_time_count #(.MIN_RADIX(MIN_RADIX), .HOUR_RADIX(HOUR_RADIX)) u_time (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick_i (tick),
    .hour_o (hour_w),
    .min_o  (min_w)
  );

  clk_alarm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .snooze_i   (snooze_s),
    .hour_i     (hour_w),
    .min_i      (min_w),
    .set_hour_i (alarm_hour),
    .set_min_i  (alarm_min),
    .state_o    (state_w)
  );

  assign show_alarm = (state_w == ST_ALARM) || (state_w == ST_SNOOZE);
  assign digit[0]   = min_w;
  assign digit[1]   = hour_w;

  generate
    for (genvar g = 0; g < N_DIG; g++) begin : g_digit
      assign seg[g] = show_alarm ? SEG_ALARM : bcd_to_seg(digit[g]);
    end
  endgenerate

  assign seg_min  = seg[0];
  assign seg_hour = seg[1];
  assign hour_bcd = hour_w;
  assign min_bcd  = min_w;
  assign state    = state_w;
endmodule

// File: tb/mixed_alarm_clock_bench.sv
module mixed_alarm_clock_bench;
  localparam int TD = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       snooze_btn;
  logic [3:0] alarm_hour, alarm_min;
  logic [7:0] seg_hour, seg_min;
  logic [3:0] hour_bcd, min_bcd;
  logic [1:0] state;

  int n_chk = 0;
  int n_fail = 0;
  int k = 0;
  int phase = 0;

  always #10 clk = ~clk;

  mixed_alarm_clock #(.TICK_DIV(TD)) u_mixed_alarm_clock (
    .clk(clk), .rst_n(rst_n), .snooze_btn(snooze_btn),
    .alarm_hour(alarm_hour), .alarm_min(alarm_min),
    .seg_hour(seg_hour), .seg_min(seg_min),
    .hour_bcd(hour_bcd), .min_bcd(min_bcd), .state(state)
  );

  function automatic int exp_seg(int d);
    case (d)
      0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
      4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
      8: return 'h7F; 9: return 'h6F; default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_time(input string req);
    int eh;
    int em;
    eh = (k % 60) / 10;
    em = k % 10;
    check(int'(hour_bcd) == eh, req, "hour", hour_bcd, eh);
    check(int'(min_bcd) == em, req, "minute", min_bcd, em);
  endtask

  task automatic next_tick();
    repeat (TD - 1 - phase) cyc();
    check_time("R2 hold");
    cyc();
    k++;
    phase = 0;
    if (k % 10 == 0) check_time("R3");
    else             check_time("R2");
  endtask

  task automatic start_run();
    int waited;
    @(negedge clk);
    rst_n = 1'b1;
    waited = 0;
    while (state != 2'd1 && waited < 6) begin
      cyc();
      waited++;
    end
    check(state == 2'd1, "R5", "TIME after INIT", state, 1);
    waited = 0;
    while (min_bcd != 4'd1 && waited < 3 * TD) begin
      cyc();
      waited++;
    end
    k = 1;
    phase = 0;
    check_time("R2 first");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    snooze_btn = 1'b0;
    alarm_hour = 4'd2;
    alarm_min = 4'd3;
    repeat (3) cyc();
    check(state == 2'd0, "R1", "reset state", state, 0);
    check(hour_bcd == 0 && min_bcd == 0, "R1", "reset time", {hour_bcd, min_bcd}, 0);
    check(seg_hour == 8'h3F && seg_min == 8'h3F, "R1", "reset seg", {seg_hour, seg_min}, 'h3F3F);

    start_run();
    alarm_hour = 4'd1;
    alarm_min = 4'd0;

    while (k < 124) begin
      next_tick();
      if (k <= 22 || (k > 40 && k < 83) || k > 83) begin
        check(seg_hour == exp_seg((k % 60) / 10), "R4", "seg_hour", seg_hour, exp_seg((k % 60) / 10));
        check(seg_min == exp_seg(k % 10), "R4", "seg_min", seg_min, exp_seg(k % 10));
      end
      if (k % 60 == 10) begin
        cyc(); phase++;
        check(state == 2'd1, "R11", "no alarm on new inputs", state, 1);
      end
      if (k == 23 || k == 83) begin
        cyc(); phase++;
        check(state == 2'd2, "R6", "ALARM entry", state, 2);
        check(seg_hour == 8'h80 && seg_min == 8'h80, "R8", "alarm seg", {seg_hour, seg_min}, 'h8080);
        cyc(); phase++;
        check(state == 2'd3, "R7", "SNOOZE after ALARM", state, 3);
      end
      if (k > 23 && k < 40) begin
        check(state == 2'd3, "R8", "SNOOZE held", state, 3);
        check(seg_min == 8'h80, "R8", "snooze seg", seg_min, 'h80);
      end
      if (k == 40) begin
        snooze_btn = 1'b1;
        repeat (2) begin cyc(); phase++; end
        check(state == 2'd3, "R9", "still SNOOZE before latency", state, 3);
        cyc(); phase++;
        check(state == 2'd1, "R9", "TIME after snooze", state, 1);
        check(seg_hour == exp_seg(4), "R4", "digits back", seg_hour, exp_seg(4));
        snooze_btn = 1'b0;
      end
      if (k == 83) begin
        snooze_btn = 1'b1;
        while (phase < TD - 1) begin
          cyc(); phase++;
          if (phase >= 5) begin
            check(state == 2'd1, "R10", "no retrigger", state, 1);
            check(min_bcd == 4'd3, "R10", "time still matches", min_bcd, 3);
          end
        end
        snooze_btn = 1'b0;
      end
      if ((k > 40 && k < 83) || k > 83)
        check(state == 2'd1, "R10", "TIME between alarms", state, 1);
    end

    @(negedge clk);
    alarm_hour = 4'd5;
    alarm_min = 4'd9;
    #3 rst_n = 1'b0;
    #2;
    check(state == 2'd0, "R1", "async reset state", state, 0);
    check(hour_bcd == 0 && min_bcd == 0, "R1", "async reset time", {hour_bcd, min_bcd}, 0);
    repeat (2) cyc();
    start_run();
    while (k < 59) next_tick();
    cyc(); phase++;
    check(state == 2'd2, "R6", "ALARM at 5:9", state, 2);
    cyc(); phase++;
    check(state == 2'd3, "R7", "SNOOZE at 5:9", state, 3);
    snooze_btn = 1'b1;
    repeat (3) begin cyc(); phase++; end
    check(state == 2'd1, "R9", "TIME after snooze", state, 1);
    snooze_btn = 1'b0;
    next_tick();
    check(hour_bcd == 0 && min_bcd == 0, "R3", "5:9 wraps", {hour_bcd, min_bcd}, 0);

    summary();
    $finish;
  end
endmodule